// File: doc/BRIEF.md
# Flash Page and EEPROM Write Sequencer

This block sits between a host that holds an image to program and a serial shifter that moves 32-bit programming instructions to a target device that is already in programming mode. The host hands over one request at a time (a flash word write, an EEPROM byte write, a flash word read, an EEPROM byte read, or a page flush) with an address and data. The block turns each request into the right series of four-byte instructions. It keeps only one instruction outstanding on the shifter at a time and waits for the shifter's response before it moves on.

Flash words go into the target's page buffer as two byte loads, the low byte first. A filled page is committed with a page-write instruction that carries the page number. The page is committed on its own when a word lands at the last offset of the page. It is also committed when the host sends a flush while loads are pending. After a page commit, and after every EEPROM byte write, the block goes quiet for a programmed number of timebase ticks. Each kind of write has its own count. When the host says the target is freshly erased, EEPROM bytes of 0xFF are dropped without any traffic. Reads return the byte or word that the shifter captured during the last byte of each read instruction.

Top module: `prog_write_sequencer`

## Requirements
- R1: A flash word write (kind 0) issues `{0x40, 0x00, offset, data[7:0]}` and then `{0x48, 0x00, offset, data[15:8]}`, where offset is `addr[5:0]` zero-extended. The low byte is always sent first.
- R2: When the word just loaded sits at offset 63, the block next issues the page commit `{0x4C, page, 0x00, 0x00}`, where page is `addr[13:6]` of that word.
- R3: A flush request (kind 4) issues the page commit for the page of the last loaded word if loads are pending since the last commit. With nothing pending it issues no instruction and returns to ready at once.
- R4: After the response to a page commit, the block issues no instruction and holds `req_ready` low until at least FLASH_WAIT_TICKS cycles with `tick` high have passed.
- R5: An EEPROM write (kind 1) issues `{0xC0, addr[15:8], addr[7:0], data[7:0]}`. The block then stays quiet and not ready for at least EE_WAIT_TICKS ticks.
- R6: An EEPROM write with `chip_erased` high and `data[7:0]` = 0xFF issues nothing and incurs no wait. `req_ready` is high again in the cycle after acceptance.
- R7: A flash read (kind 2) issues `{0x20, addr[15:8], addr[7:0], 0x00}` and then `{0x28, ...}` with the same address. It then pulses `rd_valid` for one cycle with `rd_data` = {high response byte, low response byte}.
- R8: An EEPROM read (kind 3) issues `{0xA0, addr[15:8], addr[7:0], 0x00}` and then pulses `rd_valid` with `rd_data` = {0x00, response byte}.
- R9: At most one instruction is outstanding. `cmd_valid` and `cmd_word` hold steady until `cmd_ready`, and `cmd_valid` stays low until `rsp_valid` answers the accepted instruction.
- R10: After reset, `req_ready` is high and `cmd_valid` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe used to count write waits |
| chip_erased | input | 1 | Target is erased; 0xFF EEPROM bytes are skipped |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 3 | 0 flash write, 1 EEPROM write, 2 flash read, 3 EEPROM read, 4 flush |
| req_addr | input | 16 | Word address (flash) or byte address (EEPROM) |
| req_data | input | 16 | Flash word, or EEPROM byte in bits 7:0 |
| cmd_valid | output | 1 | Instruction available to the shifter |
| cmd_ready | input | 1 | Shifter takes the instruction |
| cmd_word | output | 32 | Instruction, bits 31:24 shifted first |
| rsp_valid | input | 1 | Shifter finished the accepted instruction |
| rsp_byte | input | 8 | Byte received during the fourth instruction byte |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 16 | Read result |

## Verification
Directed cases come first. A word at offset 5 shows plain loading without a commit, and a word at offset 63 shows the automatic commit. A flush with pending loads is then set against a flush with nothing pending. An 0xFF EEPROM byte is sent with and without the erased flag, which separates the skip path from a normal write. Random traffic then mixes all five kinds over a few pages with a bias toward offset 63. It varies the handshake delay and the tick pattern to expose ordering, page tracking and wait-count errors. Each wait is checked by counting ticks between the write's response and the next instruction or `req_ready`.

// File: rtl/prog_seq_pkg.sv
// Shared definitions for the programming write sequencer.
// Assumes a 16-bit host address and 32-bit, four-byte instructions.
package prog_seq_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int INSTR_W = 32;

    typedef enum logic [2:0] {
        REQ_FLASH_WR = 3'd0,
        REQ_EE_WR    = 3'd1,
        REQ_FLASH_RD = 3'd2,
        REQ_EE_RD    = 3'd3,
        REQ_FLUSH    = 3'd4
    } req_kind_e;

    localparam logic [7:0] OP_LOAD_LO = 8'h40;
    localparam logic [7:0] OP_LOAD_HI = 8'h48;
    localparam logic [7:0] OP_COMMIT  = 8'h4C;
    localparam logic [7:0] OP_EE_WR   = 8'hC0;
    localparam logic [7:0] OP_RD_LO   = 8'h20;
    localparam logic [7:0] OP_RD_HI   = 8'h28;
    localparam logic [7:0] OP_EE_RD   = 8'hA0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LD_LO,
        S_LD_HI,
        S_COMMIT,
        S_EE_WR,
        S_RD_LO,
        S_RD_HI,
        S_EE_RD,
        S_WAIT
    } step_e;

    // Assemble four instruction bytes, first-shifted byte on top.
    function automatic logic [INSTR_W-1:0] pack_instr(
        input logic [7:0] op, input logic [7:0] b1,
        input logic [7:0] b2, input logic [7:0] b3);
        return {op, b1, b2, b3};
    endfunction

endpackage

// File: rtl/prog_instr_builder.sv
// Instruction builder: forms the 32-bit instruction for the current step.
// Assumes OFFSET_W <= 8 and PAGE_W <= 8; purely combinational.
module prog_instr_builder
    import prog_seq_pkg::*;
#(
    parameter int OFFSET_W = 6,
    parameter int PAGE_W   = 8
) (
    input  step_e                step,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    input  logic [PAGE_W-1:0]    page,
    output logic [INSTR_W-1:0]   word
);
    logic [7:0] off_byte;
    logic [7:0] page_byte;

    // Zero-extend page offset and page number to a byte.
    always_comb begin
        off_byte  = 8'(addr[OFFSET_W-1:0]);
        page_byte = 8'(page);
    end

    // Select opcode and operand bytes by step.
    always_comb begin
        case (step)
            S_LD_LO:  word = pack_instr(OP_LOAD_LO, 8'h00, off_byte, data[7:0]);
            S_LD_HI:  word = pack_instr(OP_LOAD_HI, 8'h00, off_byte, data[15:8]);
            S_COMMIT: word = pack_instr(OP_COMMIT, page_byte, 8'h00, 8'h00);
            S_EE_WR:  word = pack_instr(OP_EE_WR, addr[15:8], addr[7:0], data[7:0]);
            S_RD_LO:  word = pack_instr(OP_RD_LO, addr[15:8], addr[7:0], 8'h00);
            S_RD_HI:  word = pack_instr(OP_RD_HI, addr[15:8], addr[7:0], 8'h00);
            S_EE_RD:  word = pack_instr(OP_EE_RD, addr[15:8], addr[7:0], 8'h00);
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/prog_page_tracker.sv
// Page tracker: remembers the page of the last loaded word and whether
// loads are waiting for a commit. Assumes load and commit never coincide.
module prog_page_tracker #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_done,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              commit_done,
    output logic              pending,
    output logic [PAGE_W-1:0] page
);
    // Update pending flag and page number on load and commit completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            page    <= '0;
        end else if (load_done) begin
            pending <= 1'b1;
            page    <= load_page;
        end else if (commit_done) begin
            pending <= 1'b0;
        end
    end

    assert_commit_has_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> pending);
    assert_load_marks_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> pending);
endmodule

// File: rtl/prog_write_timer.sv
// Write-wait timer: loads the flash or EEPROM wait count and counts it
// down on timebase ticks. Assumes both counts are at least 1.
module prog_write_timer #(
    parameter int FLASH_WAIT_TICKS = 4500,
    parameter int EE_WAIT_TICKS    = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_flash,
    input  logic start_ee,
    output logic busy
);
    localparam int MAX_TICKS = (FLASH_WAIT_TICKS > EE_WAIT_TICKS) ? FLASH_WAIT_TICKS : EE_WAIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Load on a write completion, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_flash)
            cnt_q <= CNT_W'(FLASH_WAIT_TICKS);
        else if (start_ee)
            cnt_q <= CNT_W'(EE_WAIT_TICKS);
        else if (tick && busy)
            cnt_q <= cnt_q - 1'b1;
    end

    assert_count_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick && !start_flash && !start_ee |=> cnt_q == $past(cnt_q));
    assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_flash && start_ee));
endmodule

// File: rtl/prog_write_sequencer.sv
// Programming write sequencer top: accepts host requests and walks each
// through its instruction steps, one instruction outstanding at a time,
// with page commits and post-write waits. Assumes the target is already
// in programming mode and the shifter answers every accepted instruction.
module prog_write_sequencer
    import prog_seq_pkg::*;
#(
    parameter int OFFSET_W         = 6,
    parameter int PAGE_W           = 8,
    parameter int FLASH_WAIT_TICKS = 4500,
    parameter int EE_WAIT_TICKS    = 900
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                chip_erased,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_data,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [INSTR_W-1:0]  cmd_word,
    input  logic                rsp_valid,
    input  logic [7:0]          rsp_byte,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);
    localparam logic [OFFSET_W-1:0] LAST_OFFSET = '1;

    step_e               state_q, state_d;
    logic                inflight_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [7:0]          lo_q;
    logic                issuing, accept, rsp_fire, skip_ff;
    logic                page_pend;
    logic [PAGE_W-1:0]   page_q;
    logic                timer_busy;

    // Classify steps that put an instruction on the shifter port.
    always_comb begin
        issuing = (state_q == S_LD_LO) || (state_q == S_LD_HI) || (state_q == S_COMMIT) ||
                  (state_q == S_EE_WR) || (state_q == S_RD_LO) || (state_q == S_RD_HI) ||
                  (state_q == S_EE_RD);
    end

    assign req_ready = (state_q == S_IDLE);
    assign cmd_valid = issuing && !inflight_q;
    assign accept    = req_valid && req_ready;
    assign rsp_fire  = inflight_q && rsp_valid;
    assign skip_ff   = chip_erased && (req_data[7:0] == 8'hFF);

    // Choose the next step from the request kind or the completed step.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: if (req_valid) begin
                case (req_kind)
                    REQ_FLASH_WR: state_d = S_LD_LO;
                    REQ_EE_WR:    state_d = skip_ff ? S_IDLE : S_EE_WR;
                    REQ_FLASH_RD: state_d = S_RD_LO;
                    REQ_EE_RD:    state_d = S_EE_RD;
                    REQ_FLUSH:    state_d = page_pend ? S_COMMIT : S_IDLE;
                    default:      state_d = S_IDLE;
                endcase
            end
            S_LD_LO:  if (rsp_fire) state_d = S_LD_HI;
            S_LD_HI:  if (rsp_fire) state_d = (addr_q[OFFSET_W-1:0] == LAST_OFFSET) ? S_COMMIT : S_IDLE;
            S_COMMIT: if (rsp_fire) state_d = S_WAIT;
            S_EE_WR:  if (rsp_fire) state_d = S_WAIT;
            S_RD_LO:  if (rsp_fire) state_d = S_RD_HI;
            S_RD_HI:  if (rsp_fire) state_d = S_IDLE;
            S_EE_RD:  if (rsp_fire) state_d = S_IDLE;
            S_WAIT:   if (!timer_busy) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Advance the step and track whether an instruction is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            inflight_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_valid && cmd_ready)
                inflight_q <= 1'b1;
            else if (rsp_fire)
                inflight_q <= 1'b0;
        end
    end

    // Capture the request operands when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Collect read response bytes and strobe the finished result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (rsp_fire && state_q == S_RD_LO)
                lo_q <= rsp_byte;
            if (rsp_fire && state_q == S_RD_HI) begin
                rd_valid <= 1'b1;
                rd_data  <= {rsp_byte, lo_q};
            end
            if (rsp_fire && state_q == S_EE_RD) begin
                rd_valid <= 1'b1;
                rd_data  <= {8'h00, rsp_byte};
            end
        end
    end

    prog_instr_builder #(.OFFSET_W(OFFSET_W), .PAGE_W(PAGE_W)) u_builder (
        .step (state_q),
        .addr (addr_q),
        .data (data_q),
        .page (page_q),
        .word (cmd_word)
    );

    prog_page_tracker #(.PAGE_W(PAGE_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_done   (rsp_fire && state_q == S_LD_HI),
        .load_page   (addr_q[OFFSET_W+PAGE_W-1:OFFSET_W]),
        .commit_done (rsp_fire && state_q == S_COMMIT),
        .pending     (page_pend),
        .page        (page_q)
    );

    prog_write_timer #(.FLASH_WAIT_TICKS(FLASH_WAIT_TICKS), .EE_WAIT_TICKS(EE_WAIT_TICKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start_flash (rsp_fire && state_q == S_COMMIT),
        .start_ee    (rsp_fire && state_q == S_EE_WR),
        .busy        (timer_busy)
    );

    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));
    assert_quiet_in_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timer_busy |-> !cmd_valid && !req_ready);
    assert_commit_needs_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_word[31:24] == OP_COMMIT |-> page_pend);
    assert_skip_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_kind == REQ_EE_WR && skip_ff |=> req_ready && !cmd_valid);
    assert_read_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/prog_write_sequencer_bench.sv
// Bench: directed corner cases plus seeded random requests, with a
// shifter model that logs instructions and answers after a random delay.
module prog_write_sequencer_bench;
    localparam int FW = 6;
    localparam int EW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        chip_erased = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [15:0] req_data = 16'h0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_word;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_byte = 8'h0;
    logic        rd_valid;
    logic [15:0] rd_data;

    int vectors = 0;
    int miscompares = 0;

    prog_write_sequencer #(.FLASH_WAIT_TICKS(FW), .EE_WAIT_TICKS(EW)) u_prog_write_sequencer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chip_erased(chip_erased),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Target memory model: response byte derived from the instruction.
    function automatic logic [7:0] mem_byte(input logic [31:0] w);
        return w[31:24] ^ w[23:16] ^ (w[15:8] * 8'd7) ^ 8'h5A;
    endfunction

    // Shifter model state.
    logic [31:0] log_q [0:1023];
    int          log_n = 0;
    logic        pending = 1'b0;
    int          delay = 0;
    logic [31:0] cur_cmd = '0;
    int          ticks_seen = 0;
    int          wait_need = 0;
    string       wait_tag = "R4";
    int          r9_viol = 0;
    logic        prev_unacc = 1'b0;
    logic [31:0] prev_word = '0;
    int          rd_cnt = 0;
    logic [15:0] rd_last = '0;

    // Shifter and timebase model, all driven on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            tick = 1'b0;
        end else begin
            if (rsp_valid) ticks_seen = 0;
            else if (tick) ticks_seen++;
            rsp_valid = 1'b0;
            if (rd_valid) begin rd_cnt++; rd_last = rd_data; end
            if (wait_need > 0 && (req_ready || cmd_valid)) begin
                check(wait_tag, (ticks_seen >= wait_need) ? 32'd1 : 32'd0, 32'd1);
                wait_need = 0;
            end
            if (pending && cmd_valid) r9_viol++;
            if (prev_unacc && cmd_valid && cmd_word !== prev_word) r9_viol++;
            if (prev_unacc && !cmd_valid) r9_viol++;
            prev_unacc = 1'b0;
            if (cmd_ready) begin
                cmd_ready = 1'b0;
            end else if (pending) begin
                if (delay == 0) begin
                    rsp_valid = 1'b1;
                    rsp_byte  = mem_byte(cur_cmd);
                    pending   = 1'b0;
                    if (cur_cmd[31:24] == 8'h4C) begin wait_need = FW; wait_tag = "R4"; end
                    if (cur_cmd[31:24] == 8'hC0) begin wait_need = EW; wait_tag = "R5"; end
                end else delay--;
            end else if (cmd_valid) begin
                if ($urandom % 2 == 0) begin
                    log_q[log_n % 1024] = cmd_word;
                    log_n++;
                    cur_cmd   = cmd_word;
                    cmd_ready = 1'b1;
                    pending   = 1'b1;
                    delay     = $urandom % 3;
                end else begin
                    prev_unacc = 1'b1;
                    prev_word  = cmd_word;
                end
            end
            tick = ($urandom % 3 == 0);
        end
    end

    // Bench page model.
    logic       m_pend = 1'b0;
    logic [7:0] m_page = 8'h0;

    function automatic string tag_of(input logic [7:0] op, input logic [2:0] kind);
        case (op)
            8'h40, 8'h48: return "R1";
            8'h4C:        return (kind == 3'd4) ? "R3" : "R2";
            8'hC0:        return "R5";
            8'h20, 8'h28: return "R7";
            default:      return "R8";
        endcase
    endfunction

    // Issue one request, compare the logged instructions and read result.
    task automatic do_req(input logic [2:0] kind, input logic [15:0] addr,
                          input logic [15:0] data, input logic ce, output int cycles);
        logic [31:0] exp_w [0:3];
        int          n = 0;
        logic        exp_rd = 1'b0;
        logic [15:0] exp_rd_data = '0;
        int          start;
        int          rd_before;
        logic [7:0]  off;
        off = {2'b00, addr[5:0]};
        case (kind)
            3'd0: begin
                exp_w[0] = {8'h40, 8'h00, off, data[7:0]};
                exp_w[1] = {8'h48, 8'h00, off, data[15:8]};
                n = 2; m_pend = 1'b1; m_page = addr[13:6];
                if (addr[5:0] == 6'd63) begin
                    exp_w[2] = {8'h4C, m_page, 16'h0000}; n = 3; m_pend = 1'b0;
                end
            end
            3'd1: if (!(ce && data[7:0] == 8'hFF)) begin
                exp_w[0] = {8'hC0, addr, data[7:0]}; n = 1;
            end
            3'd2: begin
                exp_w[0] = {8'h20, addr, 8'h00};
                exp_w[1] = {8'h28, addr, 8'h00}; n = 2;
                exp_rd = 1'b1; exp_rd_data = {mem_byte(exp_w[1]), mem_byte(exp_w[0])};
            end
            3'd3: begin
                exp_w[0] = {8'hA0, addr, 8'h00}; n = 1;
                exp_rd = 1'b1; exp_rd_data = {8'h00, mem_byte(exp_w[0])};
            end
            default: if (m_pend) begin
                exp_w[0] = {8'h4C, m_page, 16'h0000}; n = 1; m_pend = 1'b0;
            end
        endcase
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        start = log_n; rd_before = rd_cnt;
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_data = data; chip_erased = ce;
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 0;
        while (!(req_ready && !cmd_valid && !pending && !cmd_ready)) begin
            @(negedge clk); cycles++;
        end
        @(negedge clk);
        check({tag_of(n > 0 ? exp_w[0][31:24] : 8'hC0, kind), " count"}, log_n - start, n);
        for (int k = 0; k < n && k < log_n - start; k++)
            check(tag_of(exp_w[k][31:24], kind), log_q[(start + k) % 1024], exp_w[k]);
        if (exp_rd) begin
            check(kind == 3'd2 ? "R7 strobe" : "R8 strobe", rd_cnt - rd_before, 1);
            check(kind == 3'd2 ? "R7 data" : "R8 data", {16'h0, rd_last}, {16'h0, exp_rd_data});
        end else
            check("R9 no read strobe", rd_cnt - rd_before, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        int cyc;
        void'($urandom(32'd2024));
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R10 ready", {31'h0, req_ready}, 1);
        check("R10 cmd_valid", {31'h0, cmd_valid}, 0);
        check("R10 rd_valid", {31'h0, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corner cases.
        do_req(3'd4, 16'h0000, 16'h0000, 1'b0, cyc);            // R3 flush, nothing pending
        check("R3 empty flush no wait", cyc, 0);
        do_req(3'd0, {2'b0, 8'h12, 6'd5}, 16'hBEEF, 1'b0, cyc); // R1 plain load
        do_req(3'd4, 16'h0000, 16'h0000, 1'b0, cyc);            // R3 flush commits page 0x12
        do_req(3'd0, {2'b0, 8'h34, 6'd63}, 16'hA55A, 1'b0, cyc);// R2 automatic commit
        do_req(3'd4, 16'h0000, 16'h0000, 1'b0, cyc);            // R3 nothing left
        check("R3 flush after commit no wait", cyc, 0);
        do_req(3'd1, 16'h0123, 16'h00FF, 1'b1, cyc);            // R6 skipped
        check("R6 skip no wait", cyc, 0);
        do_req(3'd1, 16'h0123, 16'h00FF, 1'b0, cyc);            // R5 written when not erased
        do_req(3'd1, 16'h0456, 16'h003C, 1'b1, cyc);            // R5 normal byte
        do_req(3'd2, 16'h1A2B, 16'h0000, 1'b0, cyc);            // R7
        do_req(3'd3, 16'h0077, 16'h0000, 1'b0, cyc);            // R8
        // Random mix.
        for (int i = 0; i < 250; i++) begin
            logic [2:0]  k;
            logic [15:0] a;
            logic [15:0] d;
            k = 3'($urandom % 5);
            d = 16'($urandom);
            if (k == 3'd0)
                a = {2'b00, 8'($urandom % 4), ($urandom % 4 == 0) ? 6'd63 : 6'($urandom)};
            else
                a = 16'($urandom);
            if (k == 3'd1 && $urandom % 3 == 0) d[7:0] = 8'hFF;
            do_req(k, a, d, 1'($urandom), cyc);
        end
        check("R9 single outstanding and stable", r9_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule